// File: doc/BRIEF.md
# Peripheral Bus Command Packet Parser

This block sits behind a bit-recovery front end on a daisy-chained bus that links a host to intelligent storage peripherals. It receives recovered bytes one at a time, qualified by a valid strobe, and pulls one command packet out of the stream at a time. Whatever comes before the start marker 0xC3 is treated as sync preamble. The preamble may vary in length and content, and it may even contain a stray 0xC3.

After it locks, the parser captures the five header fields and the two length counts. It then rebuilds the payload. Every byte on the wire carries bit 7 set, so a payload byte travels as seven data bits, and its top bit is collected into a separate MSB byte. One MSB byte leads the odd remainder, and one MSB byte leads each group of seven. Rebuilt bytes leave on a strobed byte stream. The first two odd bytes are also held as the command byte and the parameter count. The parser checks the folded two-byte checksum and the end marker 0xC8, and it reports the outcome with a one-cycle done pulse or a one-cycle error pulse.

Top module: `sppkt_parser`

## Requirements
- R1: While reset is active, and right after it, every output is zero.
- R2: Bytes received while hunting are ignored. Parsing starts at the byte 0xC3.
- R3: After a 0xC3, the next byte is accepted as destination only when bit 7 is set and its low 7 bits are no greater than MAX_UNIT. A further 0xC3 restarts the lock. Any other byte returns the parser to hunting with no error pulse.
- R4: The header fields arrive as destination, source, type, auxiliary and status. Each field output shows the low 7 bits of its byte from the cycle after that byte arrives, and holds the value until the same field is received again.
- R5: The odd-count byte (low 7 bits, 0 to 6) is followed, when it is nonzero, by an MSB byte and then by the odd bytes. Odd byte i takes bit 7 from bit 6-i of the MSB byte. The first odd byte is also presented as the command byte and the second as the parameter count.
- R6: The group count (low 7 bits) gives a number of groups. Each group is an MSB byte followed by seven bytes, and byte j of the group takes bit 7 from bit 6-j of the MSB byte. Odd bytes come before the groups in the payload stream.
- R7: Each rebuilt payload byte appears on pay_byte with pay_we high for exactly one cycle, the cycle after its data byte arrives, in the order received.
- R8: The checksum is the XOR of the seven raw header bytes (destination through group count) and all rebuilt payload bytes. It is sent as (cs | 0xAA) and then ((cs >> 1) | 0xAA). When it matches and the byte after it is 0xC8, pkt_done pulses for one cycle in the following cycle.
- R9: A checksum mismatch gives a one-cycle pkt_err pulse in the cycle after the end-marker position, and no done pulse.
- R10: Any byte other than 0xC8 at the end-marker position gives a pkt_err pulse.
- R11: Any byte with bit 7 clear that arrives after the destination aborts the packet with a pkt_err pulse, and the parser returns to hunting.
- R12: An odd count above 6 or a group count above MAX_GROUPS aborts the packet with a pkt_err pulse in the cycle after that count byte.
- R13: Cycles with byte_vld low change no state and no output, and they produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | byte_in holds a new received byte |
| byte_in | input | 8 | Recovered bus byte |
| unit_dst | output | 7 | Destination unit field |
| unit_src | output | 7 | Source unit field |
| pkt_type | output | 7 | Packet type field |
| pkt_aux | output | 7 | Auxiliary type field |
| pkt_stat | output | 7 | Status field |
| pay_we | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Rebuilt payload byte |
| cmd_byte | output | 8 | First odd payload byte |
| parm_cnt | output | 8 | Second odd payload byte |
| pkt_done | output | 1 | Packet accepted pulse |
| pkt_err | output | 1 | Packet rejected pulse |

## Verification
The bench builds the parser with MAX_UNIT set to 3 and MAX_GROUPS set to 4. A small unit limit means that ordinary sync patterns such as 0xFC, and a unit number of 4, fall outside the accepted destination range. This lets the false-start relock be tested with realistic preambles. A limit of four groups makes a payload that fills the whole group budget (28 bytes) short to send, and it makes the group-count overflow reachable with a single count byte of 0x85. Payloads of 0, 1, 2, 7, 9 and 28 bytes cover every combination of an empty or non-empty odd remainder with zero, one or several groups.

// File: rtl/sppkt_pkg.sv
package sppkt_pkg;
   localparam logic [7:0] START_MARK = 8'hC3;
   localparam logic [7:0] END_MARK   = 8'hC8;
   localparam int         GRP_LEN    = 7;
   localparam int         ODD_MAX    = GRP_LEN - 1;
   localparam logic [7:0] CS_FILL    = 8'hAA;
   localparam logic [7:0] CS_KEEP    = 8'h55;

   typedef enum logic [3:0] {
      ST_HUNT, ST_DEST, ST_SRC, ST_TYPE, ST_AUX, ST_STAT,
      ST_ODDCNT, ST_GRPCNT, ST_ODDMSB, ST_ODD, ST_GMSB, ST_GDATA,
      ST_CK1, ST_CK2, ST_END
   } pst_t;

   // rebuild the 8-bit checksum from its two folded wire bytes
   function automatic logic [7:0] unfold_cs(input logic [7:0] lo, input logic [7:0] hi);
      return (lo & CS_KEEP) | ((hi & CS_KEEP) << 1);
   endfunction
endpackage

// File: rtl/sppkt_ctrl.sv
module sppkt_ctrl
   import sppkt_pkg::*;
#(
   parameter int MAX_UNIT   = 15,
   parameter int MAX_GROUPS = 74,
   localparam int GW = $clog2(MAX_GROUPS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   output logic       lock,
   output logic [4:0] hdr_we,
   output logic       cnt_we,
   output logic       msb_we,
   output logic       dat_we,
   output logic       odd_dat,
   output logic [2:0] dat_idx,
   output logic       ck1_we,
   output logic       ck2_we,
   output logic       end_chk,
   output logic       abort
);
   pst_t          st, nxt;
   logic [2:0]    pos, odd_n;
   logic [GW-1:0] grp_left;
   logic          b7, dst_ok, cnt_bad;

   assign b7      = byte_in[7];
   assign dst_ok  = b7 && (int'(byte_in[6:0]) <= MAX_UNIT);
   assign dat_idx = pos;

   always_comb begin
      cnt_bad = 1'b0;
      if (st == ST_ODDCNT) cnt_bad = int'(byte_in[6:0]) > ODD_MAX;
      if (st == ST_GRPCNT) cnt_bad = int'(byte_in[6:0]) > MAX_GROUPS;
   end

   always_comb begin
      nxt = st; lock = 1'b0; hdr_we = '0; cnt_we = 1'b0; msb_we = 1'b0;
      dat_we = 1'b0; odd_dat = 1'b0; ck1_we = 1'b0; ck2_we = 1'b0;
      end_chk = 1'b0; abort = 1'b0;
      if (byte_vld) begin
         case (st)
            ST_HUNT: if (byte_in == START_MARK) begin lock = 1'b1; nxt = ST_DEST; end
            ST_DEST: begin
               if (byte_in == START_MARK) lock = 1'b1;
               else if (dst_ok) begin hdr_we[0] = 1'b1; nxt = ST_SRC; end
               else nxt = ST_HUNT;
            end
            default: begin
               if (!b7 || cnt_bad) begin
                  abort = 1'b1; nxt = ST_HUNT;
               end else begin
                  case (st)
                     ST_SRC:  begin hdr_we[1] = 1'b1; nxt = ST_TYPE; end
                     ST_TYPE: begin hdr_we[2] = 1'b1; nxt = ST_AUX; end
                     ST_AUX:  begin hdr_we[3] = 1'b1; nxt = ST_STAT; end
                     ST_STAT: begin hdr_we[4] = 1'b1; nxt = ST_ODDCNT; end
                     ST_ODDCNT: begin cnt_we = 1'b1; nxt = ST_GRPCNT; end
                     ST_GRPCNT: begin
                        cnt_we = 1'b1;
                        if (odd_n != 3'd0)              nxt = ST_ODDMSB;
                        else if (byte_in[6:0] != 7'd0)  nxt = ST_GMSB;
                        else                            nxt = ST_CK1;
                     end
                     ST_ODDMSB: begin msb_we = 1'b1; nxt = ST_ODD; end
                     ST_ODD: begin
                        dat_we = 1'b1; odd_dat = 1'b1;
                        if (pos == odd_n - 3'd1)
                           nxt = (grp_left != '0) ? ST_GMSB : ST_CK1;
                     end
                     ST_GMSB: begin msb_we = 1'b1; nxt = ST_GDATA; end
                     ST_GDATA: begin
                        dat_we = 1'b1;
                        if (int'(pos) == GRP_LEN - 1)
                           nxt = (grp_left == GW'(1)) ? ST_CK1 : ST_GMSB;
                     end
                     ST_CK1: begin ck1_we = 1'b1; nxt = ST_CK2; end
                     ST_CK2: begin ck2_we = 1'b1; nxt = ST_END; end
                     ST_END: begin end_chk = 1'b1; nxt = ST_HUNT; end
                     default: nxt = ST_HUNT;
                  endcase
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_HUNT; pos <= '0; odd_n <= '0; grp_left <= '0;
      end else begin
         st <= nxt;
         if (cnt_we && st == ST_ODDCNT) odd_n <= byte_in[2:0];
         if (cnt_we && st == ST_GRPCNT) grp_left <= GW'(byte_in[6:0]);
         if (msb_we) pos <= '0;
         else if (dat_we) pos <= pos + 3'd1;
         if (dat_we && !odd_dat && int'(pos) == GRP_LEN - 1) grp_left <= grp_left - GW'(1);
      end
   end
endmodule

// File: rtl/sppkt_merge.sv
module sppkt_merge
   import sppkt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       msb_we,
   input  logic [2:0] idx,
   input  logic [7:0] byte_in,
   output logic [7:0] merged
);
   logic [GRP_LEN-1:0] msb_q;
   logic [GRP_LEN-1:0] top_bit;

   always_ff @(posedge clk) begin
      if (!rst_n)      msb_q <= '0;
      else if (msb_we) msb_q <= byte_in[GRP_LEN-1:0];
   end

   // data byte k of a run draws its top bit from MSB-byte bit 6-k
   for (genvar k = 0; k < GRP_LEN; k++) begin : g_sel
      assign top_bit[k] = msb_q[GRP_LEN-1-k];
   end

   always_comb begin
      merged = {1'b0, byte_in[6:0]};
      if (int'(idx) < GRP_LEN) merged[7] = top_bit[idx];
   end
endmodule

// File: rtl/sppkt_csum.sv
module sppkt_csum
   import sppkt_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       add_raw,
   input  logic       add_dat,
   input  logic [7:0] raw,
   input  logic [7:0] dat,
   input  logic       ck1_we,
   input  logic       ck2_we,
   output logic       cs_ok
);
   logic [7:0] acc, ck1_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc <= '0; ck1_q <= '0; cs_ok <= 1'b0;
      end else begin
         if (clr)          acc <= '0;
         else if (add_raw) acc <= acc ^ raw;
         else if (add_dat) acc <= acc ^ dat;
         if (ck1_we) ck1_q <= raw;
         if (ck2_we) cs_ok <= (unfold_cs(ck1_q, raw) == acc);
      end
   end
endmodule

// File: rtl/sppkt_parser.sv
module sppkt_parser
   import sppkt_pkg::*;
#(
   parameter int MAX_UNIT   = 15,
   parameter int MAX_GROUPS = 74
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       byte_vld,
   input  logic [7:0] byte_in,
   output logic [6:0] unit_dst,
   output logic [6:0] unit_src,
   output logic [6:0] pkt_type,
   output logic [6:0] pkt_aux,
   output logic [6:0] pkt_stat,
   output logic       pay_we,
   output logic [7:0] pay_byte,
   output logic [7:0] cmd_byte,
   output logic [7:0] parm_cnt,
   output logic       pkt_done,
   output logic       pkt_err
);
   localparam int NHDR = 5;

   if (MAX_UNIT < 0 || MAX_UNIT > 127) begin : g_bad_unit
      $error("MAX_UNIT must lie in 0..127");
   end
   if (MAX_GROUPS < 1 || MAX_GROUPS > 127) begin : g_bad_grp
      $error("MAX_GROUPS must lie in 1..127");
   end

   logic [NHDR-1:0] hdr_we;
   logic lock, cnt_we, msb_we, dat_we, odd_dat, ck1_we, ck2_we, end_chk, abort, cs_ok;
   logic [2:0] dat_idx;
   logic [7:0] merged;
   logic [6:0] hdr_q [NHDR];

   sppkt_ctrl #(.MAX_UNIT(MAX_UNIT), .MAX_GROUPS(MAX_GROUPS)) u_ctrl (
      .clk, .rst_n, .byte_vld, .byte_in, .lock, .hdr_we, .cnt_we, .msb_we,
      .dat_we, .odd_dat, .dat_idx, .ck1_we, .ck2_we, .end_chk, .abort);

   sppkt_merge u_merge (
      .clk, .rst_n, .msb_we, .idx(dat_idx), .byte_in, .merged);

   sppkt_csum u_csum (
      .clk, .rst_n, .clr(lock), .add_raw(cnt_we || (hdr_we != '0)),
      .add_dat(dat_we), .raw(byte_in), .dat(merged), .ck1_we, .ck2_we, .cs_ok);

   for (genvar h = 0; h < NHDR; h++) begin : g_hdr
      always_ff @(posedge clk) begin
         if (!rst_n)         hdr_q[h] <= '0;
         else if (hdr_we[h]) hdr_q[h] <= byte_in[6:0];
      end
   end

   assign unit_dst = hdr_q[0];
   assign unit_src = hdr_q[1];
   assign pkt_type = hdr_q[2];
   assign pkt_aux  = hdr_q[3];
   assign pkt_stat = hdr_q[4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pay_we <= 1'b0; pay_byte <= '0; cmd_byte <= '0; parm_cnt <= '0;
         pkt_done <= 1'b0; pkt_err <= 1'b0;
      end else begin
         pay_we   <= dat_we;
         if (dat_we) pay_byte <= merged;
         if (odd_dat && dat_idx == 3'd0) cmd_byte <= merged;
         if (odd_dat && dat_idx == 3'd1) parm_cnt <= merged;
         pkt_done <= end_chk && cs_ok && (byte_in == END_MARK);
         pkt_err  <= abort || (end_chk && !(cs_ok && byte_in == END_MARK));
      end
   end
endmodule

// File: rtl/sppkt_parser_chk.sv
module sppkt_parser_chk #(
   parameter int MAX_UNIT = 15
) (
   input logic       clk,
   input logic       rst_n,
   input logic       byte_vld,
   input logic [7:0] byte_in,
   input logic [6:0] unit_dst,
   input logic [6:0] unit_src,
   input logic [6:0] pkt_type,
   input logic [6:0] pkt_aux,
   input logic [6:0] pkt_stat,
   input logic       pay_we,
   input logic [7:0] cmd_byte,
   input logic [7:0] parm_cnt,
   input logic       pkt_done,
   input logic       pkt_err
);
   a_r8_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_done |-> ($past(byte_vld) && $past(byte_in) == 8'hC8));

   a_r9_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(pkt_done && pkt_err));

   a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_vld) |-> (!pay_we && !pkt_done && !pkt_err));

   a_r4_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(byte_vld) |-> ($stable(unit_dst) && $stable(unit_src) &&
                            $stable(pkt_type) && $stable(pkt_aux) && $stable(pkt_stat)));

   a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pay_we |-> ($stable(cmd_byte) && $stable(parm_cnt)));

   a_r3_dst_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(unit_dst) <= MAX_UNIT);

   a_r7_we_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      pay_we |-> $past(byte_vld));
endmodule

bind sppkt_parser sppkt_parser_chk #(.MAX_UNIT(MAX_UNIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
   .unit_dst(unit_dst), .unit_src(unit_src), .pkt_type(pkt_type),
   .pkt_aux(pkt_aux), .pkt_stat(pkt_stat), .pay_we(pay_we),
   .cmd_byte(cmd_byte), .parm_cnt(parm_cnt), .pkt_done(pkt_done), .pkt_err(pkt_err));

// File: tb/sppkt_parser_bench.sv
module sppkt_parser_bench;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_UNIT   = 3;
   localparam int MAX_GROUPS = 4;

   logic clk = 1'b0, rst_n = 1'b0, byte_vld = 1'b0;
   logic [7:0] byte_in = '0;
   logic [6:0] unit_dst, unit_src, pkt_type, pkt_aux, pkt_stat;
   logic pay_we, pkt_done, pkt_err;
   logic [7:0] pay_byte, cmd_byte, parm_cnt;

   always #(CLK_PERIOD/2) clk = ~clk;

   sppkt_parser #(.MAX_UNIT(MAX_UNIT), .MAX_GROUPS(MAX_GROUPS)) u_sppkt_parser (
      .clk, .rst_n, .byte_vld, .byte_in, .unit_dst, .unit_src, .pkt_type,
      .pkt_aux, .pkt_stat, .pay_we, .pay_byte, .cmd_byte, .parm_cnt,
      .pkt_done, .pkt_err);

   int checks = 0, errors = 0, gap = 0;
   logic [6:0] e_hdr [5];
   logic [7:0] e_cmd = '0, e_parm = '0, e_pdata = '0;
   logic e_we = 1'b0, e_done = 1'b0, e_err = 1'b0;
   string e_tag = "R1";
   logic [7:0] pl [$];

   task automatic chk(string tag, string name, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, name, got, exp);
      end
   endtask

   task automatic compare_all();
      chk(e_tag, "unit_dst", {1'b0, unit_dst}, {1'b0, e_hdr[0]});
      chk(e_tag, "unit_src", {1'b0, unit_src}, {1'b0, e_hdr[1]});
      chk(e_tag, "pkt_type", {1'b0, pkt_type}, {1'b0, e_hdr[2]});
      chk(e_tag, "pkt_aux",  {1'b0, pkt_aux},  {1'b0, e_hdr[3]});
      chk(e_tag, "pkt_stat", {1'b0, pkt_stat}, {1'b0, e_hdr[4]});
      chk(e_tag, "pay_we", {7'd0, pay_we}, {7'd0, e_we});
      if (e_we) chk(e_tag, "pay_byte", pay_byte, e_pdata);
      chk(e_tag, "cmd_byte", cmd_byte, e_cmd);
      chk(e_tag, "parm_cnt", parm_cnt, e_parm);
      chk(e_tag, "pkt_done", {7'd0, pkt_done}, {7'd0, e_done});
      chk(e_tag, "pkt_err",  {7'd0, pkt_err},  {7'd0, e_err});
   endtask

   // one clock: check the previous expectation, then drive and expect anew
   task automatic step(logic v, logic [7:0] b, string tag, logic we, logic [7:0] pd,
                       logic dn, logic er, int hidx, int cidx);
      @(negedge clk);
      compare_all();
      byte_vld = v; byte_in = b;
      e_tag = tag; e_we = we; e_pdata = pd; e_done = dn; e_err = er;
      if (hidx >= 0) e_hdr[hidx] = b[6:0];
      if (cidx == 0) e_cmd = pd;
      if (cidx == 1) e_parm = pd;
   endtask

   task automatic send(logic [7:0] b, string tag, logic we = 1'b0, logic [7:0] pd = '0,
                       logic dn = 1'b0, logic er = 1'b0, int hidx = -1, int cidx = -1);
      step(1'b1, b, tag, we, pd, dn, er, hidx, cidx);
      for (int i = 0; i < gap; i++) step(1'b0, 8'hC3, "R13", 1'b0, '0, 1'b0, 1'b0, -1, -1);
   endtask

   // mode 0 good, 1 bad checksum, 2 bad end marker, 3 bit-7-clear group byte
   task automatic send_pkt(logic [6:0] d, logic [6:0] s, logic [6:0] t, logic [6:0] a,
                           logic [6:0] st, int mode);
      int n = pl.size();
      int odd = n % 7;
      int grp = n / 7;
      logic [7:0] hdr [7];
      logic [7:0] cs = '0, msb, b;
      hdr[0] = {1'b1, d}; hdr[1] = {1'b1, s}; hdr[2] = {1'b1, t};
      hdr[3] = {1'b1, a}; hdr[4] = {1'b1, st};
      hdr[5] = 8'h80 | 8'(odd); hdr[6] = 8'h80 | 8'(grp);
      for (int i = 0; i < 7; i++) cs ^= hdr[i];
      for (int i = 0; i < n; i++) cs ^= pl[i];
      send(8'hC3, "R2");
      for (int i = 0; i < 5; i++) send(hdr[i], "R4", 1'b0, '0, 1'b0, 1'b0, i);
      send(hdr[5], "R5");
      send(hdr[6], "R6");
      if (odd > 0) begin
         msb = 8'h80;
         for (int i = 0; i < odd; i++) msb[6-i] = pl[i][7];
         send(msb, "R5");
         for (int i = 0; i < odd; i++)
            send({1'b1, pl[i][6:0]}, "R5", 1'b1, pl[i], 1'b0, 1'b0, -1, (i < 2) ? i : -1);
      end
      for (int g = 0; g < grp; g++) begin
         msb = 8'h80;
         for (int j = 0; j < 7; j++) msb[6-j] = pl[odd + 7*g + j][7];
         send(msb, "R6");
         for (int j = 0; j < 7; j++) begin
            b = {1'b1, pl[odd + 7*g + j][6:0]};
            if (mode == 3) begin
               b[7] = 1'b0;
               send(b, "R11", 1'b0, '0, 1'b0, 1'b1);
               return;
            end
            send(b, "R7", 1'b1, pl[odd + 7*g + j]);
         end
      end
      b = cs | 8'hAA;
      if (mode == 1) b ^= 8'h01;
      send(b, "R8");
      send((cs >> 1) | 8'hAA, "R8");
      if (mode == 2)      send(8'hC9, "R10", 1'b0, '0, 1'b0, 1'b1);
      else if (mode == 1) send(8'hC8, "R9",  1'b0, '0, 1'b0, 1'b1);
      else                send(8'hC8, "R8",  1'b0, '0, 1'b1, 1'b0);
   endtask

   task automatic fill(int n, int seed);
      pl.delete();
      for (int i = 0; i < n; i++) pl.push_back(8'((i * 37 + seed) ^ (i << 5)));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 5; i++) e_hdr[i] = '0;
      // R1: reset state
      repeat (3) begin @(negedge clk); compare_all(); end
      rst_n = 1'b1;
      // R2: preamble then a 9-byte payload (two odd bytes plus one group)
      foreach (pl[i]) ; 
      e_tag = "R1";
      send(8'hFF, "R2"); send(8'h3F, "R2"); send(8'hCF, "R2");
      send(8'hF3, "R2"); send(8'hFC, "R2"); send(8'hFF, "R2");
      pl = '{8'h81, 8'h03, 8'h80, 8'h18, 8'h02, 8'h00, 8'h00, 8'hFF, 8'h7F};
      send_pkt(7'd1, 7'd0, 7'd0, 7'd0, 7'd0, 0);
      // R3: stray start markers, out-of-range and bit-7-clear destinations
      send(8'hC3, "R3"); send(8'hFC, "R3"); send(8'hC8, "R3");
      send(8'hC3, "R3"); send(8'h84, "R3");
      send(8'hC3, "R3"); send(8'h05, "R3");
      send(8'hC3, "R3");
      pl.delete();
      send_pkt(7'd3, 7'd2, 7'd5, 7'd6, 7'd7, 0);
      // R13: idle cycles between bytes, two-byte payload
      gap = 2;
      pl = '{8'hA5, 8'h5A};
      send_pkt(7'd2, 7'd0, 7'd1, 7'd0, 7'd3, 0);
      gap = 0;
      // R6: full group budget
      fill(28, 5);
      send_pkt(7'd1, 7'd0, 7'd0, 7'd0, 7'd0, 0);
      // R9: bad checksum, one group
      fill(7, 11);
      send_pkt(7'd2, 7'd1, 7'd1, 7'd1, 7'd1, 1);
      // R10: wrong end marker
      fill(3, 99);
      send_pkt(7'd3, 7'd0, 7'd0, 7'd0, 7'd0, 2);
      // R11: bit 7 clear inside a group
      fill(8, 40);
      send_pkt(7'd1, 7'd1, 7'd1, 7'd1, 7'd1, 3);
      // R12: odd count out of range
      send(8'hC3, "R12");
      for (int i = 0; i < 5; i++) send(8'h80 | 8'(i), "R12", 1'b0, '0, 1'b0, 1'b0, i);
      send(8'h87, "R12", 1'b0, '0, 1'b0, 1'b1);
      // R12: group count out of range
      send(8'hC3, "R12");
      for (int i = 0; i < 5; i++) send(8'h81, "R12", 1'b0, '0, 1'b0, 1'b0, i);
      send(8'h80, "R12");
      send(8'h85, "R12", 1'b0, '0, 1'b0, 1'b1);
      // recovery after errors, single odd byte
      fill(1, 200);
      send_pkt(7'd3, 7'd1, 7'd2, 7'd3, 7'd4, 0);
      step(1'b0, 8'h00, "R13", 1'b0, '0, 1'b0, 1'b0, -1, -1);
      step(1'b0, 8'h00, "R13", 1'b0, '0, 1'b0, 1'b0, -1, -1);
      @(negedge clk); compare_all();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule